// File: doc/BRIEF.md
# Vector Single-Precision to Bfloat16 Packing Converter

This block narrows two vectors of IEEE single-precision values into one vector of bfloat16 values. Each operand holds `VBYTES/4` 32-bit lanes, and the result holds `VBYTES/2` 16-bit slots. Lane i of operand U lands in even slot 2i, and lane i of operand V lands in odd slot 2i+1. The two sources therefore interleave.

Each lane goes through a fixed rounding adjustment on its 32-bit pattern, and then its upper half is kept. Any NaN collapses to one canonical pattern. The conversion logic is combinational. An optional output register, selected by a parameter, gives one-cycle latency. A valid flag travels alongside the data, so one conversion can be accepted every clock.

Top module: `fp32_bf16_pack`

## Requirements
- R1: Result bits [32i+15:32i] (slot 2i) come from operand U lane i (bits [32i+31:32i]), and result bits [32i+31:32i+16] (slot 2i+1) come from operand V lane i.
- R2: When the lowest 17 bits of a lane equal 0x08000 (an exact half with bit 16 clear), no increment is applied and the slot is the lane's upper 16 bits.
- R3: When bit 15 of a non-NaN lane is set and R2 does not apply, 0x8000 is added to the 32-bit word before bits [31:16] are taken. When bit 15 is clear, the slot is plain truncation.
- R4: Any NaN lane (exponent all ones, mantissa non-zero, quiet or signalling, either sign) yields slot value 0x7FFF.
- R5: The rounding add wraps within 32 bits. A carry out of the mantissa moves the value into the next binade, and from the largest finite binade it gives infinity (0x7F7F8000 gives 0x7F80).
- R6: With the output register enabled (default), outValid equals inValid of the previous cycle, and the result for an input accepted in one cycle appears after the next rising edge. Inputs on consecutive cycles each produce their own result.
- R7: While inValid is low, the registered result keeps its previous value.
- R8: Infinities and zeros keep their sign and exponent: 0xFF800000 gives 0xFF80, 0x80000000 gives 0x8000, 0x7F800000 gives 0x7F80.
- R9: During reset, outValid is 0 and the result vector is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands are presented this cycle |
| opU | input | VBYTES*8 | Single-precision source for the even slots |
| opV | input | VBYTES*8 | Single-precision source for the odd slots |
| outValid | output | 1 | Result vector is valid |
| outVec | output | VBYTES*8 | Packed bfloat16 result |

## Verification
The assertions assume that inValid is low while reset is held, because the first post-reset comparison of outValid against the previous inValid depends on it. They also assume that the operands are known whenever inValid is high. The bench changes inputs only on falling edges and keeps inValid low throughout reset. During hold and back-to-back sequences it drives fully defined lane patterns, so the NaN and sign checks on lane 0 always see real values.

// File: rtl/fp32_bf16_pack_pkg.sv
package fp32_bf16_pack_pkg;

  typedef struct packed {
    logic loadEn;
  } convCtrl_t;

  function automatic logic laneIsNan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
  endfunction

  function automatic logic [15:0] laneToBf(input logic [31:0] w);
    logic [31:0] adj;
    adj = w;
    if (w[16:0] == 17'h08000) adj = w;
    else if (w[15]) adj = w + 32'h0000_8000;
    if (laneIsNan(w)) adj = 32'h7FFF_FFFF;
    return adj[31:16];
  endfunction

endpackage

// File: rtl/fp32_bf16_pack_ctrl.sv
module fp32_bf16_pack_ctrl
  import fp32_bf16_pack_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output convCtrl_t ctrl,
  output logic      outValid
);

  assign ctrl.loadEn = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        outValid == $past(inValid)); // R6
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/fp32_bf16_pack_dp.sv
module fp32_bf16_pack_dp
  import fp32_bf16_pack_pkg::*;
#(
  parameter int VBYTES  = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  convCtrl_t         ctrl,
  input  logic [VBYTES*8-1:0] opU,
  input  logic [VBYTES*8-1:0] opV,
  output logic [VBYTES*8-1:0] outVec
);

  localparam int LANES = VBYTES / 4;
  localparam int VW    = VBYTES * 8;

  logic [VW-1:0] packedNext;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [31:0] uWord;
      logic [31:0] vWord;
      assign uWord = opU[32*i +: 32];
      assign vWord = opV[32*i +: 32];
      assign packedNext[32*i      +: 16] = laneToBf(uWord);
      assign packedNext[32*i + 16 +: 16] = laneToBf(vWord);
    end

    if (REG_OUT) begin : g_reg
      logic [VW-1:0] resQ;
      always_ff @(posedge clk) begin
        if (!rstN)            resQ <= '0;
        else if (ctrl.loadEn) resQ <= packedNext;
      end
      assign outVec = resQ;

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.loadEn |=> $stable(outVec)); // R7
      AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.loadEn && laneIsNan(opU[31:0])) |=> outVec[15:0] == 16'h7FFF); // R4
      AST_ODD_SIGN: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.loadEn && !laneIsNan(opV[31:0])) |=> outVec[31] == $past(opV[31])); // R1
    end else begin : g_comb
      assign outVec = packedNext;
    end
  endgenerate

endmodule

// File: rtl/fp32_bf16_pack.sv
module fp32_bf16_pack
  import fp32_bf16_pack_pkg::*;
#(
  parameter int VBYTES  = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [VBYTES*8-1:0] opU,
  input  logic [VBYTES*8-1:0] opV,
  output logic                outValid,
  output logic [VBYTES*8-1:0] outVec
);

  convCtrl_t ctrl;

  fp32_bf16_pack_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .outValid(outValid)
  );

  fp32_bf16_pack_dp #(.VBYTES(VBYTES), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opU(opU), .opV(opV), .outVec(outVec)
  );

endmodule

// File: tb/fp32_bf16_pack_tb.sv
`timescale 1ns/1ps
module fp32_bf16_pack_tb;

  localparam int VBYTES = 128;
  localparam int LANES  = VBYTES / 4;
  localparam int VW     = VBYTES * 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [VW-1:0] opU = '0;
  logic [VW-1:0] opV = '0;
  logic outValid;
  logic [VW-1:0] outVec;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp32_bf16_pack #(.VBYTES(VBYTES), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opU(opU), .opV(opV),
    .outValid(outValid), .outVec(outVec)
  );

  // Expected slot value written from the requirements.
  function automatic logic [15:0] refBf(input logic [31:0] w);
    logic [31:0] a;
    if (w[30:23] == 8'hFF && w[22:0] != 0) return 16'h7FFF;   // R4
    a = w;
    if (w[16:0] != 17'h08000 && w[15]) a = w + 32'h8000;       // R2, R3, R5
    return a[31:16];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic stepNeg();
    @(negedge clk);
  endtask

  // Drive one vector, wait for it to be registered, compare every slot.
  task automatic convertAndCheck(input logic [VW-1:0] u, input logic [VW-1:0] v, input string tag);
    int bad;
    bad = 0;
    opU = u; opV = v; inValid = 1'b1;
    stepNeg();
    inValid = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (outVec[32*i +: 16] !== refBf(u[32*i +: 32]) ||
          outVec[32*i+16 +: 16] !== refBf(v[32*i +: 32])) begin
        if (bad == 0)
          check(1'b0, tag, {outVec[32*i +: 32]}, {refBf(v[32*i +: 32]), refBf(u[32*i +: 32])});
        bad++;
      end
    end
    if (bad == 0) check(1'b1, tag, 0, 0);
    check(outValid === 1'b1, {tag, " R6 valid"}, outValid, 1);
  endtask

  task automatic splat(input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] ea, input logic [15:0] eb, input string tag);
    logic [VW-1:0] u, v;
    for (int i = 0; i < LANES; i++) begin u[32*i +: 32] = a; v[32*i +: 32] = b; end
    convertAndCheck(u, v, tag);
    check(outVec[15:0] === ea && outVec[31:16] === eb, {tag, " literal"}, outVec[31:0], {eb, ea});
  endtask

  task automatic testReset();
    check(outValid === 1'b0, "R9 outValid", outValid, 0);
    check(outVec === '0, "R9 outVec", outVec[63:0], 0);
  endtask

  task automatic testMapping();
    logic [VW-1:0] u, v;
    for (int i = 0; i < LANES; i++) begin
      u[32*i +: 32] = 32'h3F80_0000 + (i << 16);
      v[32*i +: 32] = 32'hC000_0000 + (i << 16);
    end
    convertAndCheck(u, v, "R1 mapping");
    check(outVec[32*5 +: 16] === 16'h3F85 && outVec[32*5+16 +: 16] === 16'hC005,
          "R1 lane5", outVec[32*5 +: 32], 32'hC005_3F85);
  endtask

  task automatic testRounding();
    splat(32'h3F80_8000, 32'h3F81_8000, 16'h3F80, 16'h3F82, "R2 tie even / R3 tie odd");
    splat(32'h3F80_8001, 32'h3F80_7FFF, 16'h3F81, 16'h3F80, "R3 above half / truncate");
    splat(32'hBF80_C000, 32'hBF81_0000, 16'hBF81, 16'hBF81, "R3 negative");
  endtask

  task automatic testNan();
    splat(32'h7FC0_0000, 32'h7F80_0001, 16'h7FFF, 16'h7FFF, "R4 quiet/signalling");
    splat(32'hFFFF_FFFF, 32'hFF80_8000, 16'h7FFF, 16'h7FFF, "R4 negative nan");
  endtask

  task automatic testCarry();
    splat(32'h3F7F_FFFF, 32'h7F7F_8000, 16'h3F80, 16'h7F80, "R5 binade/inf");
  endtask

  task automatic testSpecials();
    splat(32'hFF80_0000, 32'h8000_0000, 16'hFF80, 16'h8000, "R8 -inf/-zero");
    splat(32'h7F80_0000, 32'h0000_0000, 16'h7F80, 16'h0000, "R8 +inf/+zero");
  endtask

  task automatic testSweep();
    logic [VW-1:0] u, v;
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < LANES; i++) begin
        s = s * 32'd1664525 + 32'd1013904223; u[32*i +: 32] = s;
        s = s * 32'd1664525 + 32'd1013904223; v[32*i +: 32] = s;
      end
      convertAndCheck(u, v, "R3 sweep");
    end
  endtask

  task automatic testBackToBackAndHold();
    logic [VW-1:0] u1, v1, u2, v2;
    for (int i = 0; i < LANES; i++) begin
      u1[32*i +: 32] = 32'h4000_0000; v1[32*i +: 32] = 32'h4040_0000;
      u2[32*i +: 32] = 32'h4080_0000; v2[32*i +: 32] = 32'h40A0_0000;
    end
    opU = u1; opV = v1; inValid = 1'b1;
    stepNeg();
    check(outVec[31:0] === 32'h4040_4000 && outValid === 1'b1, "R6 first", outVec[31:0], 32'h4040_4000);
    opU = u2; opV = v2;
    stepNeg();
    check(outVec[31:0] === 32'h40A0_4080 && outValid === 1'b1, "R6 second", outVec[31:0], 32'h40A0_4080);
    inValid = 1'b0; opU = '1; opV = '1;
    stepNeg();
    check(outValid === 1'b0, "R6 drop", outValid, 0);
    stepNeg();
    check(outVec[31:0] === 32'h40A0_4080, "R7 hold", outVec[31:0], 32'h40A0_4080);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) stepNeg();
    testReset();
    rstN = 1'b1;
    stepNeg();
    testMapping();
    testRounding();
    testNan();
    testCarry();
    testSpecials();
    testSweep();
    testBackToBackAndHold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule